// File: doc/BRIEF.md
# Reset Start Address Selector with Erase Guard

After reset this block chooses the address where instruction fetch begins. On the first clock edge after reset is released it captures three nonvolatile inputs: a boot status byte, a boot vector byte and a force-loader request that was latched during power-up. On the second edge it presents a 16-bit start address to the fetch logic and raises a one-cycle valid strobe. If the status byte is zero and no force request is present, execution starts at address zero. In every other case the vector byte becomes the high byte of the start address and the low byte is zero. The usual vector value 0x1F gives an entry at 0x1F00.

The same block also checks flash erase requests. Flash is split into 1 kB sectors, and each sector has a protection byte. A sector erase or a 64-byte page erase is either granted or rejected. The answer is a one-cycle pulse on the clock edge after the request. When the strict input is set, the top sector is protected as a whole. Page erases in the lower half of that sector, below the loader region, are still allowed.

Top module: `boot_entry_guard`

## Requirements
- R1: `start_valid_o` is high for exactly one cycle. It rises on the second rising clock edge after `rst_n` goes high and never rises again until the next reset.
- R2: While reset is held, `start_valid_o`, `erase_grant_o` and `erase_err_o` are 0 and `start_addr_o` is 0x0000.
- R3: If the captured status byte is 0x00 and the captured force request is 0, the start address is 0x0000.
- R4: If the captured status byte is nonzero, the start address is {vector byte, 0x00}. For example, vector 0x1F gives 0x1F00.
- R5: A captured force request of 1 selects {vector byte, 0x00} even when the status byte is zero.
- R6: The status, vector and force inputs are sampled only on the first edge after reset. Later changes to them leave `start_addr_o` unchanged, and it holds its value until the next reset.
- R7: On the edge after `erase_req_i` is high, exactly one of `erase_grant_o` and `erase_err_o` pulses high for one cycle. Neither is high in a cycle that does not follow a request.
- R8: The target sector is `erase_addr_i[12:10]`. Sector k uses protection byte `sec_lock_i[8k+7:8k]`. If that byte is nonzero, the request is rejected whether it is a page erase or a sector erase.
- R9: An erase to an unprotected sector is granted when strict mode is off. This includes a sector erase of the top sector, 0x1C00 to 0x1FFF.
- R10: With `strict_i` = 1, a sector erase (`erase_page_i` = 0) of the top sector is rejected.
- R11: With `strict_i` = 1, a page erase (`erase_page_i` = 1) at 0x1C00 to 0x1DFF is granted. A page erase at 0x1E00 to 0x1FFF is rejected.
- R12: An erase address at or above 0x2000 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_status_i | input | 8 | Nonvolatile boot status byte |
| boot_vector_i | input | 8 | Nonvolatile boot vector byte (high byte of loader entry) |
| force_isp_i | input | 1 | Force-loader request latched during power-up |
| strict_i | input | 1 | Strict protection of the top sector |
| sec_lock_i | input | 64 | Per-sector protection bytes, sector k in bits [8k+7:8k] |
| erase_req_i | input | 1 | Erase request, one cycle |
| erase_page_i | input | 1 | 1 = 64-byte page erase, 0 = 1 kB sector erase |
| erase_addr_i | input | 16 | Byte address inside the target page or sector |
| start_addr_o | output | 16 | Selected execution start address |
| start_valid_o | output | 1 | One-cycle strobe marking a valid start address |
| erase_grant_o | output | 1 | Erase accepted, one-cycle pulse |
| erase_err_o | output | 1 | Erase rejected, one-cycle pulse |

## Verification
The start selection is tried with four reset patterns:
- zero status and no force;
- nonzero status with the usual vector;
- zero status with force raised and an unusual vector;
- nonzero status with force raised.

Together these show that either cause alone selects the vector and that the vector byte is passed through rather than a constant. After each capture the inputs are changed, which separates sampling once from sampling continuously. Erase requests cover a locked middle sector, an unlocked one, the top sector under both settings of strict mode, page erases on each side of 0x1E00, and an address outside flash. These cases separate the lock check, the strict rule and the range check from one another.

// File: rtl/boot_entry_guard.sv
module boot_entry_guard #(
  parameter int ADDR_W      = 16,
  parameter int NUM_SECTORS = 8,
  parameter int SECTOR_W    = 10,
  parameter int LOADER_OFS  = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              boot_status_i,
  input  logic [7:0]              boot_vector_i,
  input  logic                    force_isp_i,
  input  logic                    strict_i,
  input  logic [NUM_SECTORS*8-1:0] sec_lock_i,
  input  logic                    erase_req_i,
  input  logic                    erase_page_i,
  input  logic [ADDR_W-1:0]       erase_addr_i,
  output logic [ADDR_W-1:0]       start_addr_o,
  output logic                    start_valid_o,
  output logic                    erase_grant_o,
  output logic                    erase_err_o
);

  localparam int IDX_W   = $clog2(NUM_SECTORS);
  localparam int FLASH_W = SECTOR_W + IDX_W;

  typedef enum logic [1:0] {PH_CAPTURE, PH_RELEASE, PH_RUN} phase_t;

  phase_t     phase;
  logic [7:0] stat_q, vec_q;
  logic       force_q;

  wire take_vector = force_q || (stat_q != 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_CAPTURE;
      stat_q        <= '0;
      vec_q         <= '0;
      force_q       <= 1'b0;
      start_addr_o  <= '0;
      start_valid_o <= 1'b0;
    end else begin
      start_valid_o <= 1'b0;
      case (phase)
        PH_CAPTURE: begin
          stat_q  <= boot_status_i;
          vec_q   <= boot_vector_i;
          force_q <= force_isp_i;
          phase   <= PH_RELEASE;
        end
        PH_RELEASE: begin
          start_addr_o  <= take_vector ? ADDR_W'({vec_q, 8'h00}) : '0;
          start_valid_o <= 1'b1;
          phase         <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  logic [7:0] lock_b [NUM_SECTORS];
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_lock
    assign lock_b[g] = sec_lock_i[g*8 +: 8];
  end

  wire [IDX_W-1:0]    sec_idx   = erase_addr_i[SECTOR_W +: IDX_W];
  wire                in_range  = (erase_addr_i[ADDR_W-1:FLASH_W] == '0);
  wire                locked    = (lock_b[sec_idx] != 8'h00);
  wire                top_sec   = (sec_idx == IDX_W'(NUM_SECTORS-1));
  wire                in_loader = (erase_addr_i[SECTOR_W-1:0] >= SECTOR_W'(LOADER_OFS));
  wire                strict_no = strict_i && top_sec && (!erase_page_i || in_loader);
  wire                deny      = !in_range || locked || strict_no;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_grant_o <= 1'b0;
      erase_err_o   <= 1'b0;
    end else begin
      erase_grant_o <= erase_req_i && !deny;
      erase_err_o   <= erase_req_i && deny;
    end
  end

  // R1
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_o |=> !start_valid_o);

  // R4
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_o |-> (start_addr_o[7:0] == 8'h00));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !start_valid_o) |-> $stable(start_addr_o));

  // R7
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_grant_o || erase_err_o) |-> $past(erase_req_i));

  // R7
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_grant_o && erase_err_o));

  // R8
  lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(erase_req_i && locked)) |-> (erase_err_o && !erase_grant_o));

endmodule

// File: tb/boot_entry_guard_tb.sv
module boot_entry_guard_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  boot_status_i = '0, boot_vector_i = '0;
  logic        force_isp_i = 1'b0, strict_i = 1'b0;
  logic [63:0] sec_lock_i = '0;
  logic        erase_req_i = 1'b0, erase_page_i = 1'b0;
  logic [15:0] erase_addr_i = '0;
  logic [15:0] start_addr_o;
  logic        start_valid_o, erase_grant_o, erase_err_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  boot_entry_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .boot_status_i(boot_status_i), .boot_vector_i(boot_vector_i),
    .force_isp_i(force_isp_i), .strict_i(strict_i), .sec_lock_i(sec_lock_i),
    .erase_req_i(erase_req_i), .erase_page_i(erase_page_i), .erase_addr_i(erase_addr_i),
    .start_addr_o(start_addr_o), .start_valid_o(start_valid_o),
    .erase_grant_o(erase_grant_o), .erase_err_o(erase_err_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic boot_case(string tag, logic [7:0] st, logic [7:0] vec, logic frc, logic [15:0] exp_addr);
    @(negedge clk);
    rst_n = 1'b0;
    boot_status_i = st; boot_vector_i = vec; force_isp_i = frc;
    repeat (2) @(negedge clk);
    check({tag, " R2 reset outputs"}, {start_valid_o, erase_grant_o, erase_err_o, start_addr_o}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check({tag, " R1 no strobe after first edge"}, start_valid_o, 0);
    boot_status_i = ~st; boot_vector_i = ~vec; force_isp_i = ~frc;
    @(posedge clk); #1;
    check({tag, " R1 strobe on second edge"}, start_valid_o, 1);
    check({tag, " R3/R4/R5 start address"}, start_addr_o, exp_addr);
    @(posedge clk); #1;
    check({tag, " R1 strobe one cycle"}, start_valid_o, 0);
    repeat (4) @(posedge clk);
    #1;
    check({tag, " R6 address held, later inputs ignored"}, start_addr_o, exp_addr);
    check({tag, " R1 no second strobe"}, start_valid_o, 0);
  endtask

  task automatic erase_case(string tag, logic page, logic [15:0] addr, logic exp_grant);
    @(negedge clk);
    erase_req_i = 1'b1; erase_page_i = page; erase_addr_i = addr;
    @(negedge clk);
    erase_req_i = 1'b0;
    check({tag, " response"}, {erase_grant_o, erase_err_o}, {exp_grant, ~exp_grant});
    @(negedge clk);
    check({tag, " R7 pulse ends"}, {erase_grant_o, erase_err_o}, 2'b00);
  endtask

  initial begin
    boot_case("zero status", 8'h00, 8'h1F, 1'b0, 16'h0000);
    boot_case("nonzero status", 8'h01, 8'h1F, 1'b0, 16'h1F00);
    boot_case("forced", 8'h00, 8'h2A, 1'b1, 16'h2A00);
    boot_case("both", 8'h80, 8'h1F, 1'b1, 16'h1F00);

    sec_lock_i = '0;
    sec_lock_i[8*3 +: 8] = 8'h01;
    strict_i = 1'b0;
    erase_case("R8 locked sector 3 sector erase", 1'b0, 16'h0C00, 1'b0);
    erase_case("R8 locked sector 3 page erase", 1'b1, 16'h0FC0, 1'b0);
    erase_case("R9 unlocked sector 2", 1'b0, 16'h0800, 1'b1);
    erase_case("R9 top sector non-strict", 1'b0, 16'h1C00, 1'b1);
    erase_case("R9 loader page non-strict", 1'b1, 16'h1F00, 1'b1);
    strict_i = 1'b1;
    erase_case("R10 top sector strict", 1'b0, 16'h1C00, 1'b0);
    erase_case("R11 strict page low", 1'b1, 16'h1C00, 1'b1);
    erase_case("R11 strict page 0x1DC0", 1'b1, 16'h1DC0, 1'b1);
    erase_case("R11 strict page 0x1E00", 1'b1, 16'h1E00, 1'b0);
    erase_case("R9 strict other sector", 1'b0, 16'h0400, 1'b1);
    erase_case("R12 out of range", 1'b1, 16'h2000, 1'b0);
    sec_lock_i[8*7 +: 8] = 8'h40;
    strict_i = 1'b0;
    erase_case("R8 locked top page", 1'b1, 16'h1C40, 1'b0);

    @(negedge clk);
    check("R7 idle no response", {erase_grant_o, erase_err_o}, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 200000);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule